// File: doc/BRIEF.md
# HDLC Receive Frame Formatter

This block sits between an HDLC receiver's flag and zero-bit-removal stage and its receive FIFO. It accepts one destuffed byte per valid cycle, framed by a start marker on the first byte and an end marker on the last byte. It decides, byte by byte, what is written into the FIFO. It can keep or drop the one- or two-byte address field at the head of the frame. It can keep or drop the two frame-check bytes at the tail. Every frame it closes, whether it ended normally or was aborted, is followed by one status byte.

The frame check sequence is always verified. The check is a CRC-16 with the reflected polynomial x^16+x^12+x^5+1 and a preset of all ones. It runs over every byte of the frame, address and check bytes included. A good frame leaves the residue 0xF0B8.

When the check bytes are dropped, the tail is held back in a two-byte delay line, so those bytes never reach the FIFO. The address mode and both keep options are captured on the first byte of each frame.

Top module: `hdlc_rx_formatter`

## Requirements
- R1: After reset, with no input activity, `fifo_wr` and `msg_end` stay low.
- R2: With `push_addr` set, the address bytes of a frame are written to the FIFO first, in arrival order. With it clear, they are never written.
- R3: `addr_two` = 1 selects a 2-byte address field and `addr_two` = 0 selects a 1-byte address field. This width governs both address stripping and the valid-length limit.
- R4: With `push_fcs` set, the last two bytes of the frame (the check bytes) are written just ahead of the status byte. With it clear, they are held back and never written.
- R5: Payload bytes (those between the address field and the check bytes) are always written, in arrival order.
- R6: The status byte is the last write of each closed frame, and `msg_end` is high in exactly that write cycle. It appears on the second rising edge after the edge that samples `in_eof` (or the abort). Its layout is: bit 7 length valid, bit 5 check ok, bit 4 aborted, and bits 6 and 3..0 zero.
- R7: Status bit 5 is set when the CRC register, run over all bytes of the frame, equals 0xF0B8. This holds whether or not the check bytes are written. The bit is 0 for an aborted frame.
- R8: Status bit 7 is set when the frame is not aborted and its byte count is at least the address width + 2 with `push_fcs` set, or at least the address width + 3 with `push_fcs` clear.
- R9: `in_abort` while a frame is open (and `in_valid` low) closes it. The status then has bit 4 set and bits 7 and 5 clear, and any held-back tail bytes are discarded. `in_abort` while no frame is open writes nothing.
- R10: `addr_two`, `push_addr` and `push_fcs` are sampled on the byte carrying `in_sof`. Changing them later in the frame has no effect on that frame.
- R11: Bytes presented with `in_valid` while no frame is open and without `in_sof` are ignored and write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A destuffed byte is present on `in_data` |
| in_data | input | 8 | Received byte |
| in_sof | input | 1 | Qualified by `in_valid`: first byte of a frame |
| in_eof | input | 1 | Qualified by `in_valid`: last byte of a frame |
| in_abort | input | 1 | Abort of the open frame, given with `in_valid` low |
| addr_two | input | 1 | Address field width: 1 = two bytes, 0 = one byte |
| push_addr | input | 1 | Write the address bytes to the FIFO |
| push_fcs | input | 1 | Write the two check bytes to the FIFO |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | 8 | FIFO write data |
| msg_end | output | 1 | Pulse marking the status-byte write that ends a frame |

## Verification
The assertions assume that the upstream stage leaves at least one cycle without a start byte after each end byte. The status write uses that slot and would otherwise collide with the next frame's first write. They also assume that an abort arrives only with `in_valid` low. The bench drives every frame with at least one idle cycle after its end marker, including a case at exactly that minimum gap. It raises `in_abort` only in idle cycles, so the stimulus stays inside these rules. Option inputs are toggled only after a frame's first byte, where the block must ignore them.

// File: rtl/hdlc_rxf_pkg.sv
package hdlc_rxf_pkg;

  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned FCS_BYTES = 2;
  localparam logic [15:0] FCS_SEED    = 16'hFFFF;
  localparam logic [15:0] FCS_RESIDUE = 16'hF0B8;
  localparam logic [15:0] FCS_POLY_R  = 16'h8408;

  typedef struct packed {
    logic       frame_ok;
    logic       spare;
    logic       fcs_ok;
    logic       aborted;
    logic [3:0] zero;
  } rx_status_t;

  // one byte of the reflected CRC, least significant bit first
  function automatic logic [15:0] fcs_update(input logic [15:0] acc, input logic [7:0] b);
    logic [15:0] c;
    c = acc;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ b[i]) c = (c >> 1) ^ FCS_POLY_R;
      else             c = c >> 1;
    end
    return c;
  endfunction

  function automatic int unsigned addr_bytes(input logic two);
    return two ? 32'd2 : 32'd1;
  endfunction

  function automatic int unsigned min_frame(input logic two, input logic keep_fcs);
    return addr_bytes(two) + FCS_BYTES + (keep_fcs ? 32'd0 : 32'd1);
  endfunction

endpackage

// File: rtl/rxf_fcs_check.sv
module rxf_fcs_check
  import hdlc_rxf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              restart,
  input  logic [BYTE_W-1:0] data,
  output logic              good
);

  logic [15:0] acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  acc_q <= FCS_SEED;
    else if (en) acc_q <= fcs_update(restart ? FCS_SEED : acc_q, data);
  end

  assign good = (acc_q == FCS_RESIDUE);

  // R7
  fcs_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(acc_q));

endmodule

// File: rtl/rxf_tail_hold.sv
module rxf_tail_hold #(
  parameter int unsigned DEPTH = 2,
  parameter int unsigned W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         pop_valid,
  output logic [W-1:0] pop_data
);

  logic [DEPTH-1:0][W-1:0] slot_q;
  logic [DEPTH-1:0]        vld_q;

  assign pop_valid = push && vld_q[DEPTH-1] && !flush;
  assign pop_data  = slot_q[DEPTH-1];

  always_ff @(posedge clk) begin
    if (!rst_n)      vld_q <= '0;
    else if (flush)  vld_q <= DEPTH'(push);
    else if (push)   vld_q <= (vld_q << 1) | DEPTH'(1);
  end

  always_ff @(posedge clk) begin
    if (push) begin
      slot_q[0] <= din;
      for (int i = 1; i < DEPTH; i++) slot_q[i] <= slot_q[i-1];
    end
  end

  // R4
  tail_thermo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((vld_q + 1'b1) & vld_q) == '0);

endmodule

// File: rtl/rxf_frame_ctl.sv
module rxf_frame_ctl
  import hdlc_rxf_pkg::*;
#(
  parameter int unsigned LEN_W = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_sof,
  input  logic       in_eof,
  input  logic       in_abort,
  input  logic       addr_two,
  input  logic       push_addr,
  input  logic       push_fcs,
  input  logic       fcs_good,
  output logic       take,
  output logic       restart,
  output logic       in_addr,
  output logic       cfg_push_addr,
  output logic       cfg_push_fcs,
  output logic       close_pend,
  output rx_status_t status
);

  localparam logic [LEN_W-1:0] LEN_MAX = '1;

  logic             open_q, two_q, pa_q, pf_q, abort_q, close_q;
  logic [LEN_W-1:0] len_q;
  logic             cur_two, abort_ev, long_enough;
  logic [LEN_W-1:0] idx, len_next;

  always_comb begin
    take          = in_valid && (in_sof || open_q);
    restart       = in_valid && in_sof;
    cur_two       = in_sof ? addr_two  : two_q;
    cfg_push_addr = in_sof ? push_addr : pa_q;
    cfg_push_fcs  = in_sof ? push_fcs  : pf_q;
    idx           = in_sof ? '0 : len_q;
    len_next      = (idx == LEN_MAX) ? idx : idx + 1'b1;
    in_addr       = idx < LEN_W'(addr_bytes(cur_two));
    abort_ev      = in_abort && !in_valid && open_q;
    long_enough   = len_q >= LEN_W'(min_frame(two_q, pf_q));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      two_q   <= 1'b0;
      pa_q    <= 1'b0;
      pf_q    <= 1'b0;
      abort_q <= 1'b0;
      close_q <= 1'b0;
      len_q   <= '0;
    end else begin
      close_q <= 1'b0;
      if (take) begin
        len_q   <= len_next;
        open_q  <= !in_eof;
        close_q <= in_eof;
        if (in_sof) begin
          two_q   <= addr_two;
          pa_q    <= push_addr;
          pf_q    <= push_fcs;
          abort_q <= 1'b0;
        end
      end else if (abort_ev) begin
        open_q  <= 1'b0;
        abort_q <= 1'b1;
        close_q <= 1'b1;
      end
    end
  end

  always_comb begin
    status.frame_ok = long_enough && !abort_q;
    status.spare    = 1'b0;
    status.fcs_ok   = fcs_good && !abort_q;
    status.aborted  = abort_q;
    status.zero     = '0;
  end

  assign close_pend = close_q;

  // R9
  abort_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ev |=> close_q && abort_q && !open_q);

  // R6
  eof_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_eof) |=> !(in_valid && in_sof));

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && !restart) |=> $stable(pf_q) && $stable(pa_q) && $stable(two_q));

endmodule

// File: rtl/hdlc_rx_formatter.sv
module hdlc_rx_formatter
  import hdlc_rxf_pkg::*;
#(
  parameter int unsigned LEN_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic              in_abort,
  input  logic              addr_two,
  input  logic              push_addr,
  input  logic              push_fcs,
  output logic              fifo_wr,
  output logic [BYTE_W-1:0] fifo_data,
  output logic              msg_end
);

  logic              take, restart, in_addr, cfg_pa, cfg_pf, close_pend, fcs_good;
  rx_status_t        status;
  logic              addr_wr, body, direct_wr, tail_push, tail_pop;
  logic              byte_wr;
  logic [BYTE_W-1:0] tail_data, byte_data;

  rxf_frame_ctl #(.LEN_W(LEN_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_abort(in_abort), .addr_two(addr_two),
    .push_addr(push_addr), .push_fcs(push_fcs), .fcs_good(fcs_good),
    .take(take), .restart(restart), .in_addr(in_addr),
    .cfg_push_addr(cfg_pa), .cfg_push_fcs(cfg_pf),
    .close_pend(close_pend), .status(status)
  );

  rxf_fcs_check u_fcs (
    .clk(clk), .rst_n(rst_n), .en(take), .restart(restart),
    .data(in_data), .good(fcs_good)
  );

  rxf_tail_hold #(.DEPTH(FCS_BYTES), .W(BYTE_W)) u_tail (
    .clk(clk), .rst_n(rst_n), .flush(restart), .push(tail_push),
    .din(in_data), .pop_valid(tail_pop), .pop_data(tail_data)
  );

  always_comb begin
    addr_wr   = take && in_addr && cfg_pa;
    body      = take && !in_addr;
    direct_wr = body && cfg_pf;
    tail_push = body && !cfg_pf;
    byte_wr   = addr_wr || direct_wr || tail_pop;
    byte_data = tail_pop ? tail_data : in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fifo_wr   <= 1'b0;
      fifo_data <= '0;
      msg_end   <= 1'b0;
    end else begin
      fifo_wr   <= byte_wr || close_pend;
      fifo_data <= close_pend ? BYTE_W'(status) : byte_data;
      msg_end   <= close_pend;
    end
  end

  // R6
  single_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_wr && close_pend));

  // R6
  close_to_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    close_pend |=> msg_end && fifo_wr);

  // R6
  status_layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_end |-> (fifo_data[6] == 1'b0) && (fifo_data[3:0] == 4'h0));

  // R9
  abort_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_end && fifo_data[4]) |-> !fifo_data[7] && !fifo_data[5]);

  // R4
  tail_only_stripped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tail_pop |-> !cfg_pf);

endmodule

// File: tb/hdlc_rx_formatter_tb.sv
module hdlc_rx_formatter_tb;

  localparam int CLK_PERIOD = 10;
  typedef logic [7:0] bytes_t [];

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_abort = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       addr_two = 1'b0, push_addr = 1'b0, push_fcs = 1'b0;
  logic       fifo_wr, msg_end;
  logic [7:0] fifo_data;

  int checks = 0, errors = 0, cyc = 0, writes = 0;
  bit done = 1'b0;

  logic [7:0] exp_d[$];
  bit         exp_st[$];
  int         exp_cyc[$];
  string      exp_tag[$];

  hdlc_rx_formatter u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .in_abort(in_abort),
    .addr_two(addr_two), .push_addr(push_addr), .push_fcs(push_fcs),
    .fifo_wr(fifo_wr), .fifo_data(fifo_data), .msg_end(msg_end)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  function automatic logic [15:0] tb_crc(input bytes_t b, input int n);
    logic [15:0] r = 16'hFFFF;
    for (int k = 0; k < n; k++)
      for (int i = 0; i < 8; i++) begin
        logic fb;
        fb = r[0] ^ b[k][i];
        r  = {1'b0, r[15:1]};
        if (fb) r = r ^ 16'h8408;
      end
    return r;
  endfunction

  // address bytes + payload + two check bytes (low byte of inverted CRC first)
  task automatic build(input int alen, input int plen, input int seed, output bytes_t f);
    logic [15:0] c;
    f = new[alen + plen + 2];
    for (int k = 0; k < alen + plen; k++) f[k] = 8'(seed + k * 37);
    c = ~tb_crc(f, alen + plen);
    f[alen + plen]     = c[7:0];
    f[alen + plen + 1] = c[15:8];
  endtask

  task automatic expect_item(input logic [7:0] d, input bit st, input int c, input string tag);
    exp_d.push_back(d); exp_st.push_back(st); exp_cyc.push_back(c); exp_tag.push_back(tag);
  endtask

  // abort_at < 0: normal frame ending with in_eof; otherwise abort after abort_at bytes
  task automatic send_frame(input bytes_t f, input bit two, input bit pa, input bit pf,
                            input int abort_at, input bit flip, input int gap);
    int n, a, endc;
    bit ab, vld, cok;
    ab = (abort_at >= 0);
    n  = ab ? abort_at : f.size();
    a  = two ? 2 : 1;
    for (int k = 0; k < n; k++) begin
      if (k < a) begin
        if (pa) expect_item(f[k], 1'b0, 0, "R2 address byte");
      end else if (pf) begin
        expect_item(f[k], 1'b0, 0, (k >= n - 2) ? "R4 check byte" : "R5 payload byte");
      end else if (k < n - 2) begin
        expect_item(f[k], 1'b0, 0, "R5 payload byte");
      end
    end
    vld = !ab && (n >= a + 2 + (pf ? 0 : 1));
    cok = !ab && (tb_crc(f, n) == 16'hF0B8);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = f[k];
      in_sof = (k == 0); in_eof = (!ab && k == n - 1);
      if (k == 0) begin addr_two = two; push_addr = pa; push_fcs = pf; end
      else if (flip) begin addr_two = !two; push_addr = !pa; push_fcs = !pf; end
      endc = cyc + 2;
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    if (ab) begin
      in_abort = 1'b1;
      endc = cyc + 2;
      @(negedge clk);
      in_abort = 1'b0;
    end
    expect_item({vld, 1'b0, cok, ab, 4'h0}, 1'b1, endc, "R6 R7 R8 R9 status byte");
    repeat (gap) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && fifo_wr) begin
      writes++;
      if (exp_d.size() == 0) begin
        check(1'b0, "R11 unexpected write", fifo_data, 0);
      end else begin
        logic [7:0] d; bit st; int c; string t;
        d = exp_d.pop_front(); st = exp_st.pop_front();
        c = exp_cyc.pop_front(); t = exp_tag.pop_front();
        check(fifo_data == d, t, fifo_data, d);
        check(msg_end == st, {t, " msg_end"}, msg_end, st);
        if (st) check(cyc == c, "R6 status cycle", cyc, c);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R6 watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bytes_t f;
    int w0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(fifo_wr == 1'b0, "R1 fifo_wr after reset", fifo_wr, 0);
    check(msg_end == 1'b0, "R1 msg_end after reset", msg_end, 0);

    // R2 R3 R4 R5 option combinations
    build(1, 4, 8'h11, f); send_frame(f, 1'b0, 1'b0, 1'b0, -1, 1'b0, 2);
    build(2, 3, 8'h52, f); send_frame(f, 1'b1, 1'b1, 1'b0, -1, 1'b0, 2);
    build(1, 3, 8'hA3, f); send_frame(f, 1'b0, 1'b1, 1'b1, -1, 1'b0, 2);
    build(2, 5, 8'h04, f); send_frame(f, 1'b1, 1'b0, 1'b1, -1, 1'b0, 2);

    // R7 corrupted payload, check bytes kept and stripped
    build(1, 4, 8'h33, f); f[2] = f[2] ^ 8'h10; send_frame(f, 1'b0, 1'b1, 1'b1, -1, 1'b0, 2);
    build(2, 2, 8'h77, f); f[5] = f[5] ^ 8'h01; send_frame(f, 1'b1, 1'b0, 1'b0, -1, 1'b0, 2);

    // R8 length limits around the minimum
    build(1, 0, 8'h21, f); send_frame(f, 1'b0, 1'b1, 1'b1, -1, 1'b0, 2); // 3 bytes, kept: valid
    build(1, 0, 8'h22, f); send_frame(f, 1'b0, 1'b1, 1'b0, -1, 1'b0, 2); // 3 bytes, stripped: short
    build(1, 1, 8'h23, f); send_frame(f, 1'b0, 1'b1, 1'b0, -1, 1'b0, 2); // 4 bytes, stripped: valid
    build(2, 0, 8'h24, f); send_frame(f, 1'b1, 1'b1, 1'b1, -1, 1'b0, 2); // R3 4 bytes, two-byte address
    f = new[2]; f[0] = 8'h5A; f[1] = 8'hC3;
    send_frame(f, 1'b0, 1'b1, 1'b1, -1, 1'b0, 2);                        // 2 bytes: short

    // R9 abort mid-frame with both tail choices
    build(1, 5, 8'h61, f); send_frame(f, 1'b0, 1'b1, 1'b0, 5, 1'b0, 2);
    build(2, 5, 8'h62, f); send_frame(f, 1'b1, 1'b0, 1'b1, 4, 1'b0, 2);

    // R10 options flipped after first byte
    build(2, 4, 8'h90, f); send_frame(f, 1'b1, 1'b1, 1'b0, -1, 1'b1, 2);
    build(1, 3, 8'h91, f); send_frame(f, 1'b0, 1'b0, 1'b1, -1, 1'b1, 2);

    // R6 back-to-back frames at the minimum idle gap
    build(1, 2, 8'hB0, f); send_frame(f, 1'b0, 1'b1, 1'b1, -1, 1'b0, 1);
    build(1, 2, 8'hB1, f); send_frame(f, 1'b0, 1'b1, 1'b0, -1, 1'b0, 3);

    // R9 abort while idle, R11 stray bytes while idle
    w0 = writes;
    @(negedge clk); in_abort = 1'b1;
    @(negedge clk); in_abort = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); in_valid = 1'b1; in_data = 8'(k + 3); in_eof = (k == 3);
    end
    @(negedge clk); in_valid = 1'b0; in_eof = 1'b0;
    repeat (4) @(negedge clk);
    check(writes == w0, "R11 R9 idle activity wrote", writes, w0);

    repeat (4) @(negedge clk);
    check(exp_d.size() == 0, "R6 expected writes left over", exp_d.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule